// File: doc/BRIEF.md
# Configurable Parallel I/O Port Group

This block is one group of 24 general-purpose I/O lines, arranged as two byte-wide ports (A and B) and a third byte-wide port C whose upper and lower nibbles are handled as separate halves. Each of the four halves can be set as an input or an output by software, through a configuration byte on a small byte-wide register bus. A per-half strap input can force a half to be an output regardless of software. Every half has an output latch that drives its pins whenever the half is an output. The latch can always be read back through the bus while the half is an output.

Two resets are provided. The power-on reset, `rst_ni`, is active-low and asynchronous, and always loads the default state. The warm reset, `warm_rst_i`, is active-high and synchronous. When `retain_i` is high, a warm reset leaves all direction and output state untouched, so a host restart does not disturb the driven lines. When `retain_i` is low, a warm reset loads the defaults, just as the power-on reset does.

Pins are modelled as a three-state pad: an output-enable vector, an output-value vector and a sampled input vector. The input vector passes through a two-stage synchronizer before it reaches the read path.

Top module: `ppi_port_group`

## Requirements
- R1: A write to offset 3 sets the half directions from the written byte. Bit 4 controls port A, bit 3 port C upper, bit 1 port B and bit 0 port C lower; 1 means input and 0 means output. Bits 7, 6, 5 and 2 are ignored. A read at offset 3 returns the effective input state of each half in the same bit positions, with all other bits 0.
- R2: While the `force_out_i` bit of a half is 1 (bit 0 A, bit 1 B, bit 2 C lower, bit 3 C upper), that half drives its pins and reads back as an output, whatever its direction bit says.
- R3: A power-on reset sets every direction bit to input and clears every output latch, whatever the value of `retain_i`. Afterwards only the strap-forced halves drive, and they drive 0.
- R4: A warm reset with `retain_i` at 0 loads the same defaults as a power-on reset.
- R5: A warm reset with `retain_i` at 1 leaves every direction bit and every output latch unchanged. Bus writes made during any warm-reset cycle are ignored.
- R6: A write to offset 0, 1 or 2 loads the output latch of port A, port B or port C (both nibbles) with the written byte, whatever the direction. `pin_o` always shows the latch contents.
- R7: A read of a data offset returns, for each bit, the output latch if its half is an output, and otherwise the pin value after two clock edges of synchronization.
- R8: A direction change takes effect on the clock edge that ends the configuration write. The value already in the latch appears on `pin_o` with `pin_oe_o` set from that edge onward.
- R9: The two nibbles of port C follow their own directions independently, both for driving and for the value read at offset 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_i | input | 1 | Warm reset, active high, synchronous |
| retain_i | input | 1 | Keep state across a warm reset when 1 |
| force_out_i | input | 4 | Per-half output strap: A, B, C lower, C upper |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 2 | Register offset: 0 A, 1 B, 2 C, 3 configuration |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| pin_i | input | 24 | Pin input levels: [7:0] A, [15:8] B, [19:16] C lower, [23:20] C upper |
| pin_o | output | 24 | Pin output values, same layout |
| pin_oe_o | output | 24 | Pin output enables, same layout |

## Verification
Random sequences mix data writes, configuration writes (including random values in the ignored bits), strap changes, pin changes and warm resets with a random retain setting. After each step, all four offsets and both pin vectors are compared against a bench model, so that latch read-back can be told apart from sampled-pin read-back bit by bit. Directed cases separate a strap override from a software output setting, and a retained warm reset from a default-loading one. A power-on reset with retain high shows that the power-on reset ignores retain. A split port C setting, with one nibble in each direction, shows that each nibble takes its own path.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned N_HALF = 4;
  localparam int unsigned PIN_W  = 2 * PORT_W + 2 * NIB_W;

  localparam int unsigned H_A  = 0;
  localparam int unsigned H_B  = 1;
  localparam int unsigned H_CL = 2;
  localparam int unsigned H_CU = 3;

  typedef enum logic [1:0] {
    OFF_A   = 2'd0,
    OFF_B   = 2'd1,
    OFF_C   = 2'd2,
    OFF_CFG = 2'd3
  } reg_off_e;

  function automatic int unsigned bit_half(int unsigned i);
    if (i < PORT_W)                 return H_A;
    else if (i < 2 * PORT_W)        return H_B;
    else if (i < 2 * PORT_W + NIB_W) return H_CL;
    else                            return H_CU;
  endfunction
endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
  parameter int unsigned WIDTH  = 24,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ppi_cfg_state.sv
module ppi_cfg_state
  import ppi_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                warm_rst_i,
  input  logic                retain_i,
  input  logic                wr_en_i,
  input  logic [1:0]          addr_i,
  input  logic [PORT_W-1:0]   wdata_i,
  output logic [N_HALF-1:0]   dir_in_o,
  output logic [PIN_W-1:0]    lat_o
);
  logic [N_HALF-1:0] dir_q;
  logic [PIN_W-1:0]  lat_q;

  // warm reset outranks bus writes; retain only freezes state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      lat_q <= '0;
    end else if (warm_rst_i) begin
      if (!retain_i) begin
        dir_q <= '1;
        lat_q <= '0;
      end
    end else if (wr_en_i) begin
      unique case (reg_off_e'(addr_i))
        OFF_A:   lat_q[PORT_W-1:0]            <= wdata_i;
        OFF_B:   lat_q[2*PORT_W-1:PORT_W]     <= wdata_i;
        OFF_C:   lat_q[PIN_W-1:2*PORT_W]      <= wdata_i;
        OFF_CFG: dir_q <= {wdata_i[3], wdata_i[0], wdata_i[1], wdata_i[4]};
        default: ;
      endcase
    end
  end

  assign dir_in_o = dir_q;
  assign lat_o    = lat_q;

  AST_RETAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_rst_i && retain_i) |=> ($stable(dir_q) && $stable(lat_q))); // R5
  AST_DEFAULT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_rst_i && !retain_i) |=> (dir_q == '1 && lat_q == '0)); // R4
  AST_DATA_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !warm_rst_i && addr_i == OFF_A) |=> (lat_q[PORT_W-1:0] == $past(wdata_i))); // R6
  AST_CFG_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !warm_rst_i && addr_i == OFF_CFG) |=>
      (dir_q[H_A] == $past(wdata_i[4]) && dir_q[H_B] == $past(wdata_i[1]) &&
       dir_q[H_CL] == $past(wdata_i[0]) && dir_q[H_CU] == $past(wdata_i[3]))); // R1
endmodule

// File: rtl/ppi_rd_mux.sv
module ppi_rd_mux
  import ppi_pkg::*;
(
  input  logic [1:0]        addr_i,
  input  logic [N_HALF-1:0] half_out_i,
  input  logic [PIN_W-1:0]  lat_i,
  input  logic [PIN_W-1:0]  pin_sync_i,
  output logic [PORT_W-1:0] rdata_o
);
  logic [PIN_W-1:0]  mixed;
  logic [N_HALF-1:0] eff_in;

  for (genvar i = 0; i < PIN_W; i++) begin : g_bit
    localparam int unsigned HB = bit_half(i);
    assign mixed[i] = half_out_i[HB] ? lat_i[i] : pin_sync_i[i];
  end

  assign eff_in = ~half_out_i;

  always_comb begin
    unique case (reg_off_e'(addr_i))
      OFF_A:   rdata_o = mixed[PORT_W-1:0];
      OFF_B:   rdata_o = mixed[2*PORT_W-1:PORT_W];
      OFF_C:   rdata_o = mixed[PIN_W-1:2*PORT_W];
      OFF_CFG: rdata_o = {3'b000, eff_in[H_A], eff_in[H_CU], 1'b0, eff_in[H_B], eff_in[H_CL]};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ppi_port_group.sv
module ppi_port_group
  import ppi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic              retain_i,
  input  logic [3:0]        force_out_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [23:0]       pin_i,
  output logic [23:0]       pin_o,
  output logic [23:0]       pin_oe_o
);
  logic [N_HALF-1:0] dir_in;
  logic [N_HALF-1:0] half_out;
  logic [PIN_W-1:0]  lat;
  logic [PIN_W-1:0]  pin_sync;

  ppi_cfg_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .warm_rst_i (warm_rst_i),
    .retain_i   (retain_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .dir_in_o   (dir_in),
    .lat_o      (lat)
  );

  ppi_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  // strap wins over the software direction bit
  assign half_out = force_out_i | ~dir_in;

  for (genvar i = 0; i < PIN_W; i++) begin : g_oe
    localparam int unsigned HB = bit_half(i);
    assign pin_oe_o[i] = half_out[HB];
  end

  assign pin_o = lat;

  ppi_rd_mux u_rd (
    .addr_i     (addr_i),
    .half_out_i (half_out),
    .lat_i      (lat),
    .pin_sync_i (pin_sync),
    .rdata_o    (rdata_o)
  );

  AST_OUT_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_A && (&pin_oe_o[7:0])) |-> (rdata_o == pin_o[7:0])); // R7
  AST_STRAP_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_CFG && wdata_i[1]) |=>
      (!force_out_i[H_B] || (&pin_oe_o[15:8]))); // R2
endmodule

// File: tb/ppi_port_group_tb_top.sv
`timescale 1ns/1ps
module ppi_port_group_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        warm_rst_i = 1'b0;
  logic        retain_i = 1'b1;
  logic [3:0]  force_out_i = 4'b0010;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [7:0]  wdata_i = 8'h00;
  logic [7:0]  rdata_o;
  logic [23:0] pin_i = 24'hFFFFFF;
  logic [23:0] pin_o;
  logic [23:0] pin_oe_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [3:0]  m_dir;
  logic [23:0] m_lat;

  always #2 clk_i = ~clk_i;

  ppi_port_group dut_i (.*);

  function automatic logic [3:0] m_out();
    return force_out_i | ~m_dir;
  endfunction

  function automatic logic [23:0] m_oe();
    logic [3:0] o = m_out();
    return {{4{o[3]}}, {4{o[2]}}, {8{o[1]}}, {8{o[0]}}};
  endfunction

  function automatic logic [7:0] m_rd(input logic [1:0] a);
    logic [23:0] mix;
    logic [3:0]  ein;
    mix = (m_oe() & m_lat) | (~m_oe() & pin_i);
    ein = ~m_out();
    case (a)
      2'd0: return mix[7:0];
      2'd1: return mix[15:8];
      2'd2: return mix[23:16];
      default: return {3'b000, ein[0], ein[3], 1'b0, ein[1], ein[2]};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr_i = a;
    #0.5;
    v = rdata_o;
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(req, {24'h0, v}, {24'h0, m_rd(2'(a))});
    end
    chk(req, {8'h0, pin_oe_o}, {8'h0, m_oe()});
    chk(req, {8'h0, pin_o}, {8'h0, m_lat});
  endtask

  task automatic settle();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (!warm_rst_i) begin
      case (a)
        2'd0: m_lat[7:0]   = d;
        2'd1: m_lat[15:8]  = d;
        2'd2: m_lat[23:16] = d;
        default: m_dir = {d[3], d[0], d[1], d[4]};
      endcase
    end
  endtask

  task automatic warm(input logic keep, input logic with_wr);
    @(negedge clk_i);
    warm_rst_i = 1'b1; retain_i = keep;
    wr_en_i = with_wr; addr_i = 2'd0; wdata_i = 8'h3C;
    @(negedge clk_i);
    warm_rst_i = 1'b0; wr_en_i = 1'b0;
    if (!keep) begin m_dir = 4'hF; m_lat = 24'h0; end
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_1234));
    m_dir = 4'hF; m_lat = 24'h0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    settle();
    // R3: power-on with retain high still gives defaults, B strapped
    check_all("R3");
    rd(2'd3, v); chk("R3 cfg", {24'h0, v}, 32'h19);

    // R1: only ignored bits set -> all halves output
    bus_wr(2'd3, 8'hE4);
    settle();
    check_all("R1");
    rd(2'd3, v); chk("R1 ignored bits", {24'h0, v}, 32'h00);

    // R2: all-input write, strapped B stays output
    bus_wr(2'd3, 8'h1B);
    settle();
    check_all("R2");
    chk("R2 oe B", {24'h0, pin_oe_o[15:8]}, 32'hFF);

    // R8: latch loaded while input, then direction flips
    bus_wr(2'd0, 8'h5A);
    chk("R8 before", {24'h0, pin_oe_o[7:0]}, 32'h00);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 2'd3; wdata_i = 8'h0B;
    @(posedge clk_i); #0.5;
    wr_en_i = 1'b0;
    m_dir = 4'b1110;
    chk("R8 oe", {24'h0, pin_oe_o[7:0]}, 32'hFF);
    chk("R8 val", {24'h0, pin_o[7:0]}, 32'h5A);
    settle();

    // R9: C upper output, C lower input
    pin_i[23:16] = 8'h3C;
    bus_wr(2'd3, 8'h13);
    bus_wr(2'd2, 8'hA5);
    settle();
    rd(2'd2, v); chk("R9 split", {24'h0, v}, 32'hAC);
    chk("R9 oe", {8'h0, pin_oe_o}, {8'h0, 24'hF0FF00});
    check_all("R9");

    // R5: retained warm reset, concurrent write ignored
    bus_wr(2'd1, 8'h77);
    warm(1'b1, 1'b1);
    settle();
    check_all("R5");
    chk("R5 A latch", {24'h0, pin_o[7:0]}, 32'h5A);

    // R4: non-retained warm reset
    warm(1'b0, 1'b0);
    settle();
    check_all("R4");
    rd(2'd3, v); chk("R4 cfg", {24'h0, v}, 32'h19);

    // R3: power-on reset with retain high after state was changed
    bus_wr(2'd3, 8'h00);
    bus_wr(2'd1, 8'hC3);
    @(negedge clk_i);
    retain_i = 1'b1; rst_ni = 1'b0;
    m_dir = 4'hF; m_lat = 24'h0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    settle();
    check_all("R3 por");

    // random mix: R6 R7 R1 R2 R4 R5 R9
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 8;
      case (op)
        0, 1, 2: bus_wr(2'(op), 8'($urandom));
        3: bus_wr(2'd3, 8'($urandom));
        4: begin @(negedge clk_i); pin_i = 24'($urandom); end
        5: begin @(negedge clk_i); force_out_i = 4'($urandom); end
        6: warm(1'($urandom), 1'b0);
        default: @(negedge clk_i);
      endcase
      settle();
      check_all("R6 R7 random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule